// File: doc/BRIEF.md
# Test Instruction Decoder with Bypass and Identification Registers

This block is the instruction and data-register layer that sits behind a boundary-scan test access port controller. It holds a 4-bit instruction register, a 1-bit bypass register and a 32-bit identification register. A separate state machine supplies one-cycle strobes for capture, shift and update of the instruction path and the data path. The block decodes the active instruction into three things: the serial path routed to the test data output, the mode for the boundary cells, and a global enable that floats every output pin.

The serial output changes only on the falling test-clock edge. It is enabled only while an instruction or data shift is in progress. The boundary register itself lives outside the block. The block receives that register's serial output and hands back capture, shift and update strobes, gated so that they reach the boundary cells only while the boundary register is the selected path. Reset is synchronous and active high, and it leaves the identification instruction active.

Top module: `scan_instr_unit`

## Requirements
- R1: After reset the active instruction is IDCODE (0011). In that state `bsr_sel`=0, `cell_mode`=00, `out_hiz`=0 and `tdo_oe`=0.
- R2: A capture-IR cycle loads the instruction shift register with 0001, whose two least significant bits are 01. Shifting the instruction path then presents those bits at `tdo`, least significant first.
- R3: The decoded outputs change only at the edge that ends an update-IR cycle. Data shifted into the instruction path has no effect on them before that edge.
- R4: IDCODE (0011) selects the identification register. Capture-DR loads it with {version[3:0], part[15:0], maker[10:0], 1}, occupying bits 31..28, 27..12, 11..1 and 0. Shift-DR emits the register least significant bit first, and `tdi` bits appear after 32 shifts.
- R5: BYPASS (1111), and every code without its own meaning (0110 to 1110), select the 1-bit bypass register. Capture-DR clears it, so the first shifted bit is 0, and each `tdi` bit appears at `tdo` one shift later.
- R6: EXTEST (0000) sets `bsr_sel`=1 and `cell_mode`=01 (cells drive the output pins). During shift-DR, `tdo` carries `bsr_so`.
- R7: SAMPLE/PRELOAD (0001) sets `bsr_sel`=1 and `cell_mode`=00 (normal pass-through). During shift-DR, `tdo` carries `bsr_so`.
- R8: INTEST (0010) sets `bsr_sel`=1 and `cell_mode`=10 (cells drive the core inputs). During shift-DR, `tdo` carries `bsr_so`.
- R9: CLAMP (0100) sets `cell_mode`=01 and `bsr_sel`=0, and uses the bypass path as in R5.
- R10: HIGHZ (0101) sets `out_hiz`=1, `bsr_sel`=0 and `cell_mode`=00, and uses the bypass path. Every other instruction leaves `out_hiz`=0.
- R11: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 exactly in cycles with `shf_ir` or `shf_dr` asserted.
- R12: `bsr_cap`, `bsr_shift` and `bsr_upd` repeat `cap_dr`, `shf_dr` and `upd_dr` while `bsr_sel`=1, and stay 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_ir | input | 1 | Capture-IR state strobe |
| shf_ir | input | 1 | Shift-IR state strobe |
| upd_ir | input | 1 | Update-IR state strobe |
| cap_dr | input | 1 | Capture-DR state strobe |
| shf_dr | input | 1 | Shift-DR state strobe |
| upd_dr | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for tdo |
| bsr_sel | output | 1 | Boundary register is the selected data path |
| cell_mode | output | 2 | Boundary cell mode: 00 pass, 01 drive pins, 10 drive core |
| out_hiz | output | 1 | Float all output pins |
| bsr_cap | output | 1 | Gated capture strobe to boundary cells |
| bsr_shift | output | 1 | Gated shift strobe to boundary cells |
| bsr_upd | output | 1 | Gated update strobe to boundary cells |

## Verification
The assertions check several properties on every cycle. The decoded controls stay frozen without an update-IR strobe. The capture pattern lands in the instruction shift register. The output enable tracks the shift strobes. High impedance never coexists with a boundary selection, and the boundary strobes never fire while the boundary path is deselected. Some behaviours can only be shown by the bench's scenarios. These are the bit order and content of the identification word, the one-cycle bypass delay with random data, the per-instruction decode including random unused codes, and the fact that `tdo` holds its value until the falling edge.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int IR_W = 4;
  typedef logic [IR_W-1:0] instr_t;

  localparam instr_t OP_EXTEST = 4'b0000;
  localparam instr_t OP_SAMPLE = 4'b0001;
  localparam instr_t OP_INTEST = 4'b0010;
  localparam instr_t OP_IDCODE = 4'b0011;
  localparam instr_t OP_CLAMP  = 4'b0100;
  localparam instr_t OP_HIGHZ  = 4'b0101;
  localparam instr_t OP_BYPASS = 4'b1111;

  localparam instr_t IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

  typedef enum logic [1:0] {
    CELL_PASS       = 2'd0,
    CELL_DRIVE_PINS = 2'd1,
    CELL_DRIVE_CORE = 2'd2
  } cell_mode_e;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BSR = 2'd2
  } dr_path_e;

  typedef struct packed {
    dr_path_e   path;
    cell_mode_e mode;
    logic       hiz;
  } decode_t;
endpackage

// File: rtl/scan_ir_reg.sv
module scan_ir_reg
  import scan_pkg::*;
(
  input  logic   tck,
  input  logic   rst,
  input  logic   cap,
  input  logic   shf,
  input  logic   upd,
  input  logic   tdi,
  output instr_t shift_q,
  output instr_t instr_q
);
  always_ff @(posedge tck) begin
    if (rst) begin
      shift_q <= IR_CAPTURE;
      instr_q <= OP_IDCODE;
    end else begin
      if (cap)
        shift_q <= IR_CAPTURE;
      else if (shf)
        shift_q <= {tdi, shift_q[IR_W-1:1]};
      if (upd)
        instr_q <= shift_q;
    end
  end
endmodule

// File: rtl/scan_decode.sv
module scan_decode
  import scan_pkg::*;
(
  input  instr_t  instr,
  output decode_t dec
);
  always_comb begin
    dec = '{path: PATH_BYP, mode: CELL_PASS, hiz: 1'b0};
    unique case (instr)
      OP_EXTEST: dec = '{path: PATH_BSR, mode: CELL_DRIVE_PINS, hiz: 1'b0};
      OP_SAMPLE: dec = '{path: PATH_BSR, mode: CELL_PASS,       hiz: 1'b0};
      OP_INTEST: dec = '{path: PATH_BSR, mode: CELL_DRIVE_CORE, hiz: 1'b0};
      OP_IDCODE: dec = '{path: PATH_ID,  mode: CELL_PASS,       hiz: 1'b0};
      OP_CLAMP:  dec = '{path: PATH_BYP, mode: CELL_DRIVE_PINS, hiz: 1'b0};
      OP_HIGHZ:  dec = '{path: PATH_BYP, mode: CELL_PASS,       hiz: 1'b1};
      default:   dec = '{path: PATH_BYP, mode: CELL_PASS,       hiz: 1'b0};
    endcase
  end
endmodule

// File: rtl/scan_dr_regs.sv
module scan_dr_regs
  import scan_pkg::*;
#(
  parameter int ID_W = 32,
  parameter logic [ID_W-1:0] ID_VALUE = '1
) (
  input  logic     tck,
  input  logic     rst,
  input  logic     cap,
  input  logic     shf,
  input  logic     tdi,
  input  dr_path_e path,
  output logic     byp_so,
  output logic     id_so
);
  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_q <= 1'b0;
      id_q  <= ID_VALUE;
    end else begin
      if (path == PATH_BYP) begin
        if (cap)      byp_q <= 1'b0;
        else if (shf) byp_q <= tdi;
      end
      if (path == PATH_ID) begin
        if (cap)      id_q <= ID_VALUE;
        else if (shf) id_q <= {tdi, id_q[ID_W-1:1]};
      end
    end
  end

  assign byp_so = byp_q;
  assign id_so  = id_q[0];
endmodule

// File: rtl/scan_instr_unit.sv
module scan_instr_unit
  import scan_pkg::*;
#(
  parameter int VER_W  = 4,
  parameter int PART_W = 16,
  parameter int MFR_W  = 11,
  parameter logic [VER_W-1:0]  ID_VER  = 4'h3,
  parameter logic [PART_W-1:0] ID_PART = 16'hA5C1,
  parameter logic [MFR_W-1:0]  ID_MFR  = 11'h2B5
) (
  input  logic       tck,
  input  logic       rst,
  input  logic       cap_ir,
  input  logic       shf_ir,
  input  logic       upd_ir,
  input  logic       cap_dr,
  input  logic       shf_dr,
  input  logic       upd_dr,
  input  logic       tdi,
  input  logic       bsr_so,
  output logic       tdo,
  output logic       tdo_oe,
  output logic       bsr_sel,
  output logic [1:0] cell_mode,
  output logic       out_hiz,
  output logic       bsr_cap,
  output logic       bsr_shift,
  output logic       bsr_upd
);
  localparam int ID_W = VER_W + PART_W + MFR_W + 1;
  localparam logic [ID_W-1:0] ID_VALUE = {ID_VER, ID_PART, ID_MFR, 1'b1};

  instr_t  ir_shift_q;
  instr_t  ir_active_q;
  decode_t dec;
  logic    byp_so;
  logic    id_so;
  logic    dr_so;

  scan_ir_reg u_ir (
    .tck     (tck),
    .rst     (rst),
    .cap     (cap_ir),
    .shf     (shf_ir),
    .upd     (upd_ir),
    .tdi     (tdi),
    .shift_q (ir_shift_q),
    .instr_q (ir_active_q)
  );

  scan_decode u_dec (
    .instr (ir_active_q),
    .dec   (dec)
  );

  scan_dr_regs #(
    .ID_W     (ID_W),
    .ID_VALUE (ID_VALUE)
  ) u_dr (
    .tck    (tck),
    .rst    (rst),
    .cap    (cap_dr),
    .shf    (shf_dr),
    .tdi    (tdi),
    .path   (dec.path),
    .byp_so (byp_so),
    .id_so  (id_so)
  );

  always_comb begin
    unique case (dec.path)
      PATH_ID:  dr_so = id_so;
      PATH_BSR: dr_so = bsr_so;
      default:  dr_so = byp_so;
    endcase
  end

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shf_ir | shf_dr;
      if (shf_ir)      tdo <= ir_shift_q[0];
      else if (shf_dr) tdo <= dr_so;
      else             tdo <= 1'b0;
    end
  end

  assign bsr_sel   = (dec.path == PATH_BSR);
  assign cell_mode = dec.mode;
  assign out_hiz   = dec.hiz;
  assign bsr_cap   = bsr_sel & cap_dr;
  assign bsr_shift = bsr_sel & shf_dr;
  assign bsr_upd   = bsr_sel & upd_dr;
endmodule

// File: rtl/scan_instr_chk.sv
module scan_instr_chk (
  input logic       tck,
  input logic       rst,
  input logic       cap_ir,
  input logic       shf_ir,
  input logic       upd_ir,
  input logic       shf_dr,
  input logic       cap_dr,
  input logic       upd_dr,
  input logic       tdo_oe,
  input logic       bsr_sel,
  input logic [1:0] cell_mode,
  input logic       out_hiz,
  input logic       bsr_cap,
  input logic       bsr_shift,
  input logic       bsr_upd,
  input logic [3:0] ir_shift_q
);
  assert_ir_capture_R2: assert property (@(posedge tck) disable iff (rst)
    cap_ir |=> (ir_shift_q[1:0] == 2'b01));

  assert_hold_until_update_R3: assert property (@(posedge tck) disable iff (rst)
    !upd_ir |=> ($stable(cell_mode) && $stable(bsr_sel) && $stable(out_hiz)));

  assert_mode_legal_R8: assert property (@(posedge tck) disable iff (rst)
    cell_mode != 2'b11);

  assert_hiz_no_bsr_R10: assert property (@(posedge tck) disable iff (rst)
    out_hiz |-> (!bsr_sel && cell_mode == 2'b00));

  assert_oe_tracks_shift_R11: assert property (@(posedge tck) disable iff (rst)
    tdo_oe == (shf_ir || shf_dr));

  assert_gated_strobes_R12: assert property (@(posedge tck) disable iff (rst)
    !bsr_sel |-> !(bsr_cap || bsr_shift || bsr_upd));

  assert_gated_pass_R12: assert property (@(posedge tck) disable iff (rst)
    bsr_sel |-> (bsr_cap == cap_dr && bsr_shift == shf_dr && bsr_upd == upd_dr));
endmodule

bind scan_instr_unit scan_instr_chk chk_i (
  .tck        (tck),
  .rst        (rst),
  .cap_ir     (cap_ir),
  .shf_ir     (shf_ir),
  .upd_ir     (upd_ir),
  .shf_dr     (shf_dr),
  .cap_dr     (cap_dr),
  .upd_dr     (upd_dr),
  .tdo_oe     (tdo_oe),
  .bsr_sel    (bsr_sel),
  .cell_mode  (cell_mode),
  .out_hiz    (out_hiz),
  .bsr_cap    (bsr_cap),
  .bsr_shift  (bsr_shift),
  .bsr_upd    (bsr_upd),
  .ir_shift_q (ir_shift_q)
);

// File: tb/scan_instr_unit_tb.sv
module scan_instr_unit_tb_top;
  logic tck = 1'b0;
  logic rst = 1'b1;
  logic cap_ir = 0, shf_ir = 0, upd_ir = 0;
  logic cap_dr = 0, shf_dr = 0, upd_dr = 0;
  logic tdi = 0, bsr_so = 0;
  logic tdo, tdo_oe, bsr_sel, out_hiz, bsr_cap, bsr_shift, bsr_upd;
  logic [1:0] cell_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] EXP_ID = {4'h3, 16'hA5C1, 11'h2B5, 1'b1};

  logic din  [0:63];
  logic dout [0:63];
  logic bso  [0:63];

  always #5 tck = ~tck;

  scan_instr_unit dut_i (
    .tck(tck), .rst(rst),
    .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir),
    .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr),
    .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .bsr_sel(bsr_sel), .cell_mode(cell_mode),
    .out_hiz(out_hiz), .bsr_cap(bsr_cap), .bsr_shift(bsr_shift), .bsr_upd(bsr_upd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(input logic [3:0] c);
    if (c == 4'b0000 || c == 4'b0100) return 2'b01;
    if (c == 4'b0010) return 2'b10;
    return 2'b00;
  endfunction

  function automatic bit exp_sel(input logic [3:0] c);
    return (c == 4'b0000 || c == 4'b0001 || c == 4'b0010);
  endfunction

  function automatic bit exp_hiz(input logic [3:0] c);
    return (c == 4'b0101);
  endfunction

  task automatic next_cycle();
    @(posedge tck); #1;
  endtask

  task automatic load_ir(input logic [3:0] code, output logic [3:0] seen);
    logic [1:0] m0;
    logic s0, h0;
    cap_ir = 1; #8; next_cycle(); cap_ir = 0;
    m0 = cell_mode; s0 = bsr_sel; h0 = out_hiz;
    for (int i = 0; i < 4; i++) begin
      shf_ir = 1; tdi = code[i];
      #8;
      seen[i] = tdo;
      check(cell_mode == m0 && bsr_sel == s0 && out_hiz == h0, "R3 hold during shift-IR",
            {cell_mode, bsr_sel, out_hiz}, {m0, s0, h0});
      next_cycle();
    end
    shf_ir = 0; tdi = 0; upd_ir = 1; #8;
    check(cell_mode == m0, "R3 hold until update edge", cell_mode, m0);
    next_cycle(); upd_ir = 0;
  endtask

  task automatic shift_dr(input int n);
    cap_dr = 1; #8;
    check(bsr_cap == exp_sel(dut_code), "R12 gated capture", bsr_cap, exp_sel(dut_code));
    next_cycle(); cap_dr = 0;
    for (int i = 0; i < n; i++) begin
      shf_dr = 1; tdi = din[i]; bsr_so = bso[i];
      #8;
      dout[i] = tdo;
      next_cycle();
    end
    shf_dr = 0; tdi = 0; bsr_so = 0; upd_dr = 1; #8;
    check(bsr_upd == exp_sel(dut_code), "R12 gated update", bsr_upd, exp_sel(dut_code));
    next_cycle(); upd_dr = 0;
  endtask

  logic [3:0] dut_code;

  task automatic fill_random(input int n);
    for (int i = 0; i < n; i++) begin
      din[i] = 1'($urandom);
      bso[i] = 1'($urandom);
    end
  endtask

  task automatic check_decode(input logic [3:0] c, input string req);
    check(cell_mode == exp_mode(c), req, cell_mode, exp_mode(c));
    check(bsr_sel == exp_sel(c), req, bsr_sel, exp_sel(c));
    check(out_hiz == exp_hiz(c), req, out_hiz, exp_hiz(c));
  endtask

  task automatic check_bypass_path(input string req);
    fill_random(16);
    shift_dr(16);
    check(dout[0] == 1'b0, req, dout[0], 0);
    for (int i = 1; i < 16; i++)
      check(dout[i] == din[i-1], req, dout[i], din[i-1]);
  endtask

  task automatic check_bsr_path(input string req);
    fill_random(12);
    shift_dr(12);
    for (int i = 0; i < 12; i++)
      check(dout[i] == bso[i], req, dout[i], bso[i]);
  endtask

  initial begin
    logic [3:0] seen;
    void'($urandom(32'h5eed_0042));
    dut_code = 4'b0011;
    repeat (3) next_cycle();
    rst = 0;
    #8;
    // R1 reset state
    check(cell_mode == 2'b00 && bsr_sel == 0 && out_hiz == 0, "R1 reset decode",
          {cell_mode, bsr_sel, out_hiz}, 0);
    check(tdo_oe == 0, "R1 reset oe", tdo_oe, 0);
    next_cycle();

    // R4 IDCODE active from reset, then TDI follows
    fill_random(40);
    shift_dr(40);
    for (int i = 0; i < 32; i++)
      check(dout[i] == EXP_ID[i], "R4 id bit", dout[i], EXP_ID[i]);
    for (int i = 32; i < 40; i++)
      check(dout[i] == din[i-32], "R4 tdi after id", dout[i], din[i-32]);

    // R11 falling-edge timing of first shift bit
    cap_dr = 1; #8; next_cycle(); cap_dr = 0;
    shf_dr = 1; #2;
    check(tdo_oe == 0, "R11 oe before falling edge", tdo_oe, 0);
    #6;
    check(tdo_oe == 1 && tdo == EXP_ID[0], "R11 oe/tdo after falling edge", {tdo_oe, tdo}, {1'b1, EXP_ID[0]});
    next_cycle(); shf_dr = 0; #8;
    check(tdo_oe == 0, "R11 oe off outside shift", tdo_oe, 0);
    next_cycle();

    // R2 capture pattern seen on tdo; R6 EXTEST
    dut_code = 4'b0000;
    load_ir(dut_code, seen);
    check(seen == 4'b0001, "R2 capture pattern", seen, 4'b0001);
    check_decode(dut_code, "R6 extest decode");
    check_bsr_path("R6 extest path");

    dut_code = 4'b0001; load_ir(dut_code, seen);
    check_decode(dut_code, "R7 sample decode");
    check_bsr_path("R7 sample path");

    dut_code = 4'b0010; load_ir(dut_code, seen);
    check_decode(dut_code, "R8 intest decode");
    check_bsr_path("R8 intest path");

    dut_code = 4'b0100; load_ir(dut_code, seen);
    check_decode(dut_code, "R9 clamp decode");
    check_bypass_path("R9 clamp bypass path");

    dut_code = 4'b0101; load_ir(dut_code, seen);
    check_decode(dut_code, "R10 highz decode");
    check_bypass_path("R10 highz bypass path");

    dut_code = 4'b1111; load_ir(dut_code, seen);
    check_decode(dut_code, "R5 bypass decode");
    check_bypass_path("R5 bypass path");

    for (int k = 0; k < 6; k++) begin
      dut_code = 4'(6 + ($urandom % 9));
      load_ir(dut_code, seen);
      check_decode(dut_code, "R5 unused code decode");
      check_bypass_path("R5 unused code path");
    end

    // R12 strobes stay off for bypass path; R3 mid-sequence shift without update
    cap_ir = 1; #8; next_cycle(); cap_ir = 0;
    shf_ir = 1; tdi = 0;
    repeat (4) begin #8; next_cycle(); end
    shf_ir = 0; #8;
    check_decode(dut_code, "R3 no update keeps decode");
    next_cycle();

    dut_code = 4'b0011; load_ir(dut_code, seen);
    fill_random(32); shift_dr(32);
    for (int i = 0; i < 32; i++)
      check(dout[i] == EXP_ID[i], "R4 id reload", dout[i], EXP_ID[i]);

    // R1 reset mid-run restores IDCODE
    dut_code = 4'b0000; load_ir(dut_code, seen);
    rst = 1; next_cycle(); rst = 0; #8;
    check(cell_mode == 2'b00 && bsr_sel == 0, "R1 reset restores idcode", {cell_mode, bsr_sel}, 0);
    next_cycle();

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule